// File: doc/BRIEF.md
# SMI and SCI Interrupt Generator

This block turns two groups of platform events into processor-facing interrupt signals. Any system-management event pulls the active-low `smi_n` line low. The line stays low until software writes the end-of-SMI command. The line then goes high for a guaranteed quiet window of `GAP_CYC` bus clocks. After that window, if more events arrived in the meantime, the line goes low again. Events that arrive while the line is low, or during the quiet window, are remembered rather than dropped.

The second group consists of ACPI event sources. Each source has its own status bit that can be set and cleared. The SCI request is level-mode: it stays active while at least one status bit is set. Software chooses the interrupt line that carries the SCI and the mode that decides which lines are allowed:

- Legacy mode is the reset default and allows only IRQ 9, 10 and 11.
- APIC mode also allows IRQ 20 to 23.

A sharing flag sets the SCI pin polarity. The block also drives a one-hot vector that marks which candidate line is being asserted.

The SMI side is a state machine with three states:

| State | `smi_n` | Transitions |
|---|---|---|
| IDLE | high | IDLE to ACTIVE on any event or held event |
| ACTIVE | low | ACTIVE to GAP on an end-of-SMI write |
| GAP | high, counting | GAP to ACTIVE after the last gap cycle if events are held; GAP to IDLE otherwise |

Top module: `smi_sci_gen`

## Requirements
- R1: When the SMI machine is idle, an event bit high on `smi_evt` at a clock edge makes `smi_n` low after that edge.
- R2: Once low, `smi_n` stays low until a write with `wr_addr`=0 and `wr_data[0]`=1 (end-of-SMI). Such a write is ignored while `smi_n` is high.
- R3: After the end-of-SMI write, `smi_n` is high for exactly `GAP_CYC` (4) cycles whenever events are held. It is never high for fewer than 4 cycles between two low periods.
- R4: Events that arrive while `smi_n` is low, or during the gap (including its last cycle), are held. They cause exactly one new low period after the gap.
- R5: SCI status bit i is set by `sci_set[i]` and cleared by `sci_clr[i]`. When both are high, set wins. SCI is active while any status bit is set.
- R6: A write with `wr_addr`=1 selects the SCI line by IRQ number in `wr_data[4:0]`. Legal numbers are 9, 10 and 11 in legacy mode, and additionally 20 to 23 in APIC mode. An illegal number is ignored and the previous line is kept. `sci_irq` shows the selected number.
- R7: A write with `wr_addr`=2 sets APIC mode from `wr_data[0]` and the shared flag from `wr_data[1]`. Returning to legacy mode while routed to IRQ 20 or above reverts the route to IRQ 9.
- R8: `sci_line` bit order is IRQ 9, 10, 11, 20, 21, 22, 23 (bits 0 to 6). It is one-hot at the selected line while SCI is active and all zero otherwise.
- R9: `sci_pin` equals the SCI active level when not shared, and its inverse (active low) when shared.
- R10: The synchronous active-low reset gives the following state:
  - `smi_n` high, with no held events;
  - all SCI status bits clear;
  - route IRQ 9;
  - legacy mode, not shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smi_evt | input | N_SMI | SMI event pulses |
| sci_set | input | N_SCI | SCI status set strobes |
| sci_clr | input | N_SCI | SCI status clear strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 end-of-SMI, 1 route, 2 mode |
| wr_data | input | 8 | Write data |
| smi_n | output | 1 | SMI request, active low |
| sci_pin | output | 1 | SCI request with polarity applied |
| sci_line | output | 7 | One-hot asserted candidate line |
| sci_irq | output | 5 | Currently routed IRQ number |

## Verification
The hardest case to reach is an event that lands on the last cycle of the quiet window, or in the same cycle as the end-of-SMI write. Either one must still cause exactly one re-assertion without shortening the high period. The stimulus places events at each offset of the gap, including the cycle of the end-of-SMI write. A pseudo-random phase then mixes events, writes and SCI strobes, and the behavioural model is compared with the outputs on every cycle.

// File: rtl/smi_sci_pkg.sv
package smi_sci_pkg;

    typedef enum logic [1:0] {
        SMI_IDLE,
        SMI_ACTIVE,
        SMI_GAP
    } smi_state_e;

    localparam int          N_LINES      = 7;
    localparam logic [2:0]  LEGACY_SLOTS = 3'd3;
    localparam logic [2:0]  SLOT_NONE    = 3'd7;

    localparam logic [1:0]  ADDR_EOS   = 2'd0;
    localparam logic [1:0]  ADDR_ROUTE = 2'd1;
    localparam logic [1:0]  ADDR_MODE  = 2'd2;

    function automatic logic [2:0] irq_to_slot(input logic [4:0] irq);
        logic [2:0] s;
        unique case (irq)
            5'd9:    s = 3'd0;
            5'd10:   s = 3'd1;
            5'd11:   s = 3'd2;
            5'd20:   s = 3'd3;
            5'd21:   s = 3'd4;
            5'd22:   s = 3'd5;
            5'd23:   s = 3'd6;
            default: s = SLOT_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [4:0] slot_to_irq(input logic [2:0] slot);
        if (slot < LEGACY_SLOTS)
            return 5'd9 + {2'b00, slot};
        else
            return 5'd17 + {2'b00, slot};
    endfunction

endpackage

// File: rtl/smi_fsm.sv
module smi_fsm
    import smi_sci_pkg::*;
#(
    parameter int N_EVT   = 4,
    parameter int GAP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt,
    input  logic             eos_wr,
    output logic             smi_n
);

    localparam int             CNT_W    = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

    smi_state_e       state_q, state_d;
    logic             pend_q, pend_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             any_evt;

    assign any_evt = |evt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
            pend_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SMI_IDLE: begin
                if (pend_q || any_evt) begin
                    state_d = SMI_ACTIVE;
                    pend_d  = 1'b0;
                end
            end
            SMI_ACTIVE: begin
                pend_d = pend_q | any_evt;
                if (eos_wr) begin
                    state_d = SMI_GAP;
                    cnt_d   = '0;
                end
            end
            SMI_GAP: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = (pend_q || any_evt) ? SMI_ACTIVE : SMI_IDLE;
                    pend_d  = 1'b0;
                end else begin
                    cnt_d  = cnt_q + 1'b1;
                    pend_d = pend_q | any_evt;
                end
            end
            default: state_d = SMI_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        smi_n = (state_q != SMI_ACTIVE);
    end

    // checker state: length of the current high run and whether a low was seen
    logic [7:0] hi_run;
    logic       was_low;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run  <= '0;
            was_low <= 1'b0;
        end else begin
            if (smi_n) begin
                if (hi_run != 8'hFF) hi_run <= hi_run + 8'd1;
            end else begin
                hi_run  <= '0;
                was_low <= 1'b1;
            end
        end
    end

    // R1
    idle_evt_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_n && state_q == SMI_IDLE && any_evt) |=> !smi_n);

    // R2
    hold_until_eos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_n && !eos_wr) |=> !smi_n);

    // R3
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (was_low && !smi_n && $past(smi_n)) |-> (hi_run >= 8'(GAP_CYC)));

    // R3
    eos_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_n && eos_wr) |=> smi_n);

endmodule

// File: rtl/sci_src_bank.sv
module sci_src_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set,
    input  logic [N_SRC-1:0] clr,
    output logic             active
);

    logic [N_SRC-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | set;
    end

    assign active = |status_q;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> active);

    // R5
    drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set == '0 && (clr | ~status_q) == '1) |=> !active);

endmodule

// File: rtl/sci_router.sv
module sci_router
    import smi_sci_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               route_wr,
    input  logic [4:0]         route_irq,
    input  logic               mode_wr,
    input  logic               apic_in,
    input  logic               shared_in,
    input  logic               active,
    output logic [N_LINES-1:0] line_vec,
    output logic               pin,
    output logic [4:0]         irq_num
);

    logic [2:0] slot_q;
    logic       apic_q, shared_q;
    logic [2:0] req_slot;
    logic       req_ok;

    always_comb begin
        req_slot = irq_to_slot(route_irq);
        req_ok   = (req_slot < LEGACY_SLOTS) || (apic_q && req_slot != SLOT_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= 3'd0;
            apic_q   <= 1'b0;
            shared_q <= 1'b0;
        end else begin
            if (route_wr && req_ok) slot_q <= req_slot;
            if (mode_wr) begin
                apic_q   <= apic_in;
                shared_q <= shared_in;
                if (!apic_in && slot_q >= LEGACY_SLOTS) slot_q <= 3'd0;
            end
        end
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign line_vec[g] = active && (slot_q == 3'(g));
    end

    assign pin     = active ^ shared_q;
    assign irq_num = slot_to_irq(slot_q);

    // R6
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_wr && !req_ok && !mode_wr) |=> $stable(irq_num));

    // R8
    line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_vec));

    // R7
    legacy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apic_q |-> (irq_num <= 5'd11 && irq_num >= 5'd9));

endmodule

// File: rtl/smi_sci_gen.sv
module smi_sci_gen
    import smi_sci_pkg::*;
#(
    parameter int N_SMI   = 4,
    parameter int N_SCI   = 8,
    parameter int GAP_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SMI-1:0]   smi_evt,
    input  logic [N_SCI-1:0]   sci_set,
    input  logic [N_SCI-1:0]   sci_clr,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output logic               smi_n,
    output logic               sci_pin,
    output logic [N_LINES-1:0] sci_line,
    output logic [4:0]         sci_irq
);

    logic eos_wr, route_wr, mode_wr, sci_active;

    assign eos_wr   = wr_en && (wr_addr == ADDR_EOS) && wr_data[0];
    assign route_wr = wr_en && (wr_addr == ADDR_ROUTE);
    assign mode_wr  = wr_en && (wr_addr == ADDR_MODE);

    smi_fsm #(.N_EVT(N_SMI), .GAP_CYC(GAP_CYC)) u_smi (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (smi_evt),
        .eos_wr (eos_wr),
        .smi_n  (smi_n)
    );

    sci_src_bank #(.N_SRC(N_SCI)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (sci_set),
        .clr    (sci_clr),
        .active (sci_active)
    );

    sci_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_wr  (route_wr),
        .route_irq (wr_data[4:0]),
        .mode_wr   (mode_wr),
        .apic_in   (wr_data[0]),
        .shared_in (wr_data[1]),
        .active    (sci_active),
        .line_vec  (sci_line),
        .pin       (sci_pin),
        .irq_num   (sci_irq)
    );

endmodule

// File: tb/tb_smi_sci_gen.sv
module tb_smi_sci_gen;

    localparam int N_SMI = 4;
    localparam int N_SCI = 8;
    localparam int GAP   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SMI-1:0] smi_evt = '0;
    logic [N_SCI-1:0] sci_set = '0;
    logic [N_SCI-1:0] sci_clr = '0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic             smi_n, sci_pin;
    logic [6:0]       sci_line;
    logic [4:0]       sci_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    smi_sci_gen #(.N_SMI(N_SMI), .N_SCI(N_SCI), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .smi_evt(smi_evt), .sci_set(sci_set),
        .sci_clr(sci_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .smi_n(smi_n), .sci_pin(sci_pin), .sci_line(sci_line), .sci_irq(sci_irq)
    );

    // behavioural reference model
    int          m_phase;     // 0 quiet, 1 asserted, 2 gap
    int          m_gap_left;
    bit          m_held;
    bit [N_SCI-1:0] m_src;
    int          m_irq;
    bit          m_apic, m_shared;
    int          legal_q[$];

    initial begin
        m_phase = 0; m_gap_left = 0; m_held = 0; m_src = '0;
        m_irq = 9; m_apic = 0; m_shared = 0;
    end

    function automatic bit irq_legal(int irq, bit apic);
        if (irq >= 9 && irq <= 11) return 1;
        if (apic && irq >= 20 && irq <= 23) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit ev, eos;
        ev  = (smi_evt != 0);
        eos = wr_en && wr_addr == 2'd0 && wr_data[0];
        if (!rst_n) begin
            m_phase = 0; m_held = 0; m_src = '0; m_irq = 9; m_apic = 0; m_shared = 0;
        end else begin
            if (m_phase == 0) begin
                if (ev || m_held) begin m_phase = 1; m_held = 0; end
            end else if (m_phase == 1) begin
                if (ev) m_held = 1;
                if (eos) begin m_phase = 2; m_gap_left = GAP; end
            end else begin
                if (ev) m_held = 1;
                m_gap_left--;
                if (m_gap_left == 0) begin
                    m_phase = m_held ? 1 : 0;
                    m_held = 0;
                end
            end
            m_src = (m_src & ~sci_clr) | sci_set;
            if (wr_en && wr_addr == 2'd1 && irq_legal(int'(wr_data[4:0]), m_apic))
                m_irq = int'(wr_data[4:0]);
            if (wr_en && wr_addr == 2'd2) begin
                m_apic = wr_data[0]; m_shared = wr_data[1];
                if (!m_apic && m_irq >= 20) m_irq = 9;
            end
        end
    end

    function automatic int irq_bit(int irq);
        return (irq <= 11) ? irq - 9 : irq - 17;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison and direct gap-length measurement
    int hi_run = 0;
    bit seen_low = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit act;
            int exp_line;
            act = (m_src != 0);
            exp_line = act ? (1 << irq_bit(m_irq)) : 0;
            chk("R1 R2 R4 smi_n", int'(smi_n), (m_phase == 1) ? 0 : 1);
            chk("R5 R8 sci_line", int'(sci_line), exp_line);
            chk("R9 sci_pin", int'(sci_pin), int'(act ^ m_shared));
            chk("R6 R7 sci_irq", int'(sci_irq), m_irq);
            if (smi_n) hi_run++;
            else begin
                if (seen_low && hi_run > 0) chk("R3 high run >= 4", (hi_run >= GAP) ? 1 : 0, 1);
                hi_run = 0;
                seen_low = 1;
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic pulse_evt(logic [N_SMI-1:0] e);
        smi_evt = e; cyc(1); smi_evt = '0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R10 reset state
        chk("R10 smi_n reset", int'(smi_n), 1);
        chk("R10 sci_irq reset", int'(sci_irq), 9);
        chk("R10 sci_line reset", int'(sci_line), 0);
        chk("R10 sci_pin reset", int'(sci_pin), 0);

        // R2: end-of-SMI while high ignored
        wr(2'd0, 8'h01);
        cyc(2);
        // R1 assert and hold
        pulse_evt(4'b0010);
        chk("R1 low after event", int'(smi_n), 0);
        cyc(6);
        chk("R2 still low", int'(smi_n), 0);
        wr(2'd0, 8'h00);                 // bit0 clear: no release
        chk("R2 eos bit0=0 ignored", int'(smi_n), 0);
        wr(2'd0, 8'h01);
        chk("R3 high after eos", int'(smi_n), 1);
        cyc(8);
        chk("R3 idle without pending", int'(smi_n), 1);

        // R4: events at each offset of active/gap
        for (int off = 0; off <= GAP; off++) begin
            pulse_evt(4'b0001);
            cyc(2);
            pulse_evt(4'b0100);          // held while low
            wr(2'd0, 8'h01);
            cyc(off);
            if (off < GAP) pulse_evt(4'b1000);
            cyc(GAP + 2);
            wr(2'd0, 8'h01);
            cyc(GAP + 2);
        end
        // R4: event together with end-of-SMI write
        pulse_evt(4'b0001);
        cyc(2);
        smi_evt = 4'b0001; wr(2'd0, 8'h01); smi_evt = '0;
        cyc(GAP - 1);
        chk("R4 still high in gap", int'(smi_n), 1);
        cyc(1);
        chk("R4 re-asserted after gap", int'(smi_n), 0);
        wr(2'd0, 8'h01);
        cyc(GAP + 2);

        // R5 SCI sources
        sci_set = 8'h05; cyc(1); sci_set = '0;
        chk("R8 line IRQ9", int'(sci_line), 7'b0000001);
        sci_clr = 8'h01; cyc(1); sci_clr = '0;
        chk("R5 still active", int'(sci_pin), 1);
        sci_set = 8'h04; sci_clr = 8'h04; cyc(1); sci_set = '0; sci_clr = '0;
        chk("R5 set wins", int'(sci_pin), 1);
        sci_clr = 8'h04; cyc(1); sci_clr = '0;
        chk("R5 cleared", int'(sci_pin), 0);

        // R6 routing
        wr(2'd1, 8'd21);
        chk("R6 apic-only ignored in legacy", int'(sci_irq), 9);
        wr(2'd1, 8'd11);
        chk("R6 legal 11", int'(sci_irq), 11);
        wr(2'd1, 8'd12);
        chk("R6 illegal 12 ignored", int'(sci_irq), 11);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'd22);
        chk("R6 apic 22", int'(sci_irq), 22);
        sci_set = 8'h80; cyc(1); sci_set = '0;
        chk("R8 line IRQ22", int'(sci_line), 7'b0100000);
        wr(2'd2, 8'h03);
        chk("R9 shared active low", int'(sci_pin), 0);
        sci_clr = 8'h80; cyc(1); sci_clr = '0;
        chk("R9 shared idle high", int'(sci_pin), 1);
        wr(2'd2, 8'h00);
        chk("R7 revert to 9", int'(sci_irq), 9);

        // mixed pseudo-random phase
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            smi_evt = (lfsr[3:0] == 4'h0) ? lfsr[7:4] : '0;
            sci_set = (lfsr[6:4] == 3'd0) ? lfsr[15:8] : '0;
            sci_clr = (lfsr[6:4] == 3'd1) ? lfsr[15:8] : '0;
            wr_en   = (lfsr[9:8] == 2'd0);
            wr_addr = lfsr[11:10] == 2'd3 ? 2'd0 : lfsr[11:10];
            wr_data = {3'b000, lfsr[14:10]} ^ 8'd9;
            if (wr_addr == 2'd0) wr_data = 8'h01;
            cyc(1);
        end
        smi_evt = '0; sci_set = '0; sci_clr = '0; wr_en = 0;
        cyc(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule